// File: doc/BRIEF.md
# Load Alias Hold Predictor

This block sits next to the load issue stage of an out-of-order core. It keeps a small, fully associative table of partial load instruction addresses (tags). A load goes into the table only after it has been caught reading memory before an older store to the same location had written it. Each load that comes up for issue is looked up in the table. A load that misses issues speculatively, and the block looks at no store addresses for it. A load that hits is held back while any store older than it in the store queue has no resolved address yet. The block names the oldest such store, and the scheduler replays the load once that store resolves.

Training tags arrive on a valid/ready stream from the violation detector. A tag is accepted on a cycle where `train_valid` and `train_ready` are both high. `train_ready` drops only while the synchronous clear is asserted, so the producer must hold its tag until the next cycle. Lookup is a combinational query on plain pins. The store queue supplies a per-entry "allocated but address unknown" vector, the index of its oldest entry, and the number of entries older than the load. The block reports only a hit flag, a hold decision and the index of the store to wait on. Scheduling and replay are handled elsewhere.

Top module: `alias_hold_predictor`

## Requirements
- R1: After reset every table entry is invalid, so a valid lookup of any tag reports `lookup_hit`=0 and `lookup_hold`=0.
- R2: A tag accepted on the training stream at a clock edge makes a lookup of that same tag hit from the following cycle onward.
- R3: Accepting a tag that is already in the table leaves the table and the replacement position unchanged.
- R4: New tags are written to slots 0,1,2,... in turn, wrapping after the last slot. The 17th distinct tag accepted after reset (default 16 slots) therefore evicts the 1st tag, and all other tags stay in the table.
- R5: A lookup that misses never holds, whatever the store queue state.
- R6: A hitting lookup holds when at least one older store has an unresolved address. `lookup_wait_idx` then gives the store-queue index of the oldest such store.
- R7: Only the `sq_older_cnt` entries starting at `sq_head` count as older. Unresolved entries outside that window are ignored, and a count of 0 never holds.
- R8: The older-store window wraps around the circular store queue. Age is measured from `sq_head`, not by index value. A count equal to the queue depth covers every entry.
- R9: A hitting lookup with no unresolved older store does not hold, and `lookup_wait_idx` reads 0.
- R10: While `clear_i` is high during a clock edge, every entry is invalidated at that edge and the replacement position returns to slot 0.
- R11: When `lookup_valid` is low, `lookup_hit` and `lookup_hold` are both 0.
- R12: `train_ready` is low exactly while `clear_i` is high. A tag offered in that cycle is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous invalidate of the whole table |
| train_valid | input | 1 | Training tag offered |
| train_ready | output | 1 | Training tag can be accepted |
| train_tag | input | TAG_W (12) | Partial address of a load that aliased |
| lookup_valid | input | 1 | A load is being considered for issue |
| lookup_tag | input | TAG_W (12) | Partial address of that load |
| sq_head | input | log2(SQ_DEPTH) (4) | Store-queue index of the oldest store |
| sq_older_cnt | input | log2(SQ_DEPTH)+1 (5) | Number of stores older than the load |
| sq_pending | input | SQ_DEPTH (16) | Per store-queue entry: allocated with address unknown |
| lookup_hit | output | 1 | Tag found in the table |
| lookup_hold | output | 1 | Load must wait |
| lookup_wait_idx | output | log2(SQ_DEPTH) (4) | Store to wait on, 0 when not holding |

## Verification
The hardest case to reach from the ports is one where a duplicate training tag has wrongly used up a replacement slot. The table still holds every distinct tag, so a plain hit/miss check does not reveal it. The bench trains two tags, repeats the first, fills the remaining slots with fresh tags and then trains one more. It checks that the first tag was evicted while the second one survived. Those two outcomes only come out this way when the duplicate left the replacement order alone. Wrap-around windows are driven with the head near the top of the queue, with unresolved bits set on both sides of the wrap point.

// File: rtl/ahp_pkg.sv
package ahp_pkg;
  // Combined outcome of one lookup before the wait index is attached.
  typedef struct packed {
    logic hit;
    logic hold;
  } verdict_t;
endpackage

// File: rtl/ahp_tag_cam.sv
module ahp_tag_cam #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic             wr_dup
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] slot_vld;
  logic [TAG_W-1:0]   slot_tag [ENTRIES];
  logic [ENTRIES-1:0] rd_match;
  logic [ENTRIES-1:0] wr_match;
  logic [PTR_W-1:0]   rr_ptr;

  // One comparator pair per slot: one for the lookup port, one for the
  // training port's duplicate check.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign rd_match[g] = slot_vld[g] && (slot_tag[g] == rd_tag);
    assign wr_match[g] = slot_vld[g] && (slot_tag[g] == wr_tag);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_vld[g] <= 1'b0;
        slot_tag[g] <= '0;
      end else if (clear_i) begin
        slot_vld[g] <= 1'b0;
      end else if (wr_en && (rr_ptr == PTR_W'(g))) begin
        slot_vld[g] <= 1'b1;
        slot_tag[g] <= wr_tag;
      end
    end
  end

  assign rd_hit = |rd_match;
  assign wr_dup = |wr_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (clear_i) begin
      rr_ptr <= '0;
    end else if (wr_en) begin
      rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/ahp_oldest_pending.sv
module ahp_oldest_pending #(
  parameter int SQ_DEPTH = 16
) (
  input  logic [$clog2(SQ_DEPTH)-1:0] head,
  input  logic [$clog2(SQ_DEPTH):0]   older_cnt,
  input  logic [SQ_DEPTH-1:0]         pending,
  output logic                        found,
  output logic [$clog2(SQ_DEPTH)-1:0] oldest_idx
);
  localparam int IDX_W = $clog2(SQ_DEPTH);
  localparam int CNT_W = IDX_W + 1;

  // Rotate the pending vector so bit 0 is the oldest store, then keep only
  // the positions older than the load.
  logic [SQ_DEPTH-1:0] aged;
  for (genvar g = 0; g < SQ_DEPTH; g++) begin : g_age
    logic [IDX_W-1:0] pos;
    assign pos     = head + IDX_W'(g);
    assign aged[g] = pending[pos] && (CNT_W'(g) < older_cnt);
  end

  logic [IDX_W-1:0] first_off;
  always_comb begin
    first_off = '0;
    for (int i = SQ_DEPTH - 1; i >= 0; i--) begin
      if (aged[i]) first_off = IDX_W'(i);
    end
  end

  assign found      = |aged;
  assign oldest_idx = head + first_off;
endmodule

// File: rtl/ahp_verdict.sv
module ahp_verdict
  import ahp_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             lookup_valid,
  input  logic             cam_hit,
  input  logic             store_found,
  input  logic [IDX_W-1:0] store_idx,
  output verdict_t         verdict,
  output logic [IDX_W-1:0] wait_idx
);
  always_comb begin
    verdict.hit  = lookup_valid && cam_hit;
    verdict.hold = verdict.hit && store_found;
    wait_idx     = verdict.hold ? store_idx : '0;
  end
endmodule

// File: rtl/alias_hold_predictor.sv
module alias_hold_predictor
  import ahp_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int TAG_W    = 12,
  parameter int SQ_DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear_i,
  input  logic                        train_valid,
  output logic                        train_ready,
  input  logic [TAG_W-1:0]            train_tag,
  input  logic                        lookup_valid,
  input  logic [TAG_W-1:0]            lookup_tag,
  input  logic [$clog2(SQ_DEPTH)-1:0] sq_head,
  input  logic [$clog2(SQ_DEPTH):0]   sq_older_cnt,
  input  logic [SQ_DEPTH-1:0]         sq_pending,
  output logic                        lookup_hit,
  output logic                        lookup_hold,
  output logic [$clog2(SQ_DEPTH)-1:0] lookup_wait_idx
);
  localparam int IDX_W = $clog2(SQ_DEPTH);

  logic             cam_hit;
  logic             train_dup;
  logic             train_wr;
  logic             store_found;
  logic [IDX_W-1:0] store_idx;
  verdict_t         verdict;

  assign train_ready = !clear_i;
  assign train_wr    = train_valid && train_ready && !train_dup;

  ahp_tag_cam #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W)
  ) u_cam (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear_i),
    .wr_en   (train_wr),
    .wr_tag  (train_tag),
    .rd_tag  (lookup_tag),
    .rd_hit  (cam_hit),
    .wr_dup  (train_dup)
  );

  ahp_oldest_pending #(
    .SQ_DEPTH (SQ_DEPTH)
  ) u_find (
    .head       (sq_head),
    .older_cnt  (sq_older_cnt),
    .pending    (sq_pending),
    .found      (store_found),
    .oldest_idx (store_idx)
  );

  ahp_verdict #(
    .IDX_W (IDX_W)
  ) u_verdict (
    .lookup_valid (lookup_valid),
    .cam_hit      (cam_hit),
    .store_found  (store_found),
    .store_idx    (store_idx),
    .verdict      (verdict),
    .wait_idx     (lookup_wait_idx)
  );

  assign lookup_hit  = verdict.hit;
  assign lookup_hold = verdict.hold;
endmodule

// File: rtl/ahp_checker.sv
module ahp_checker #(
  parameter int SQ_DEPTH = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        clear_i,
  input logic                        train_valid,
  input logic                        train_ready,
  input logic                        lookup_valid,
  input logic [$clog2(SQ_DEPTH):0]   sq_older_cnt,
  input logic [SQ_DEPTH-1:0]         sq_pending,
  input logic                        lookup_hit,
  input logic                        lookup_hold,
  input logic [$clog2(SQ_DEPTH)-1:0] lookup_wait_idx
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |-> (!lookup_hit && !lookup_hold)); // R11
  AST_MISS_NEVER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && !lookup_hit) |-> !lookup_hold); // R5
  AST_WAIT_ON_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hold |-> sq_pending[lookup_wait_idx]); // R6
  AST_EMPTY_WINDOW_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_older_cnt == '0) |-> !lookup_hold); // R7
  AST_IDX_ZERO_UNHELD: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_hold |-> (lookup_wait_idx == '0)); // R9
  AST_CLEAR_BLOCKS_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |-> !train_ready); // R12
  AST_TABLE_EMPTY_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !train_valid) |=> !lookup_hit); // R10
endmodule

bind alias_hold_predictor ahp_checker #(
  .SQ_DEPTH (SQ_DEPTH)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .clear_i         (clear_i),
  .train_valid     (train_valid),
  .train_ready     (train_ready),
  .lookup_valid    (lookup_valid),
  .sq_older_cnt    (sq_older_cnt),
  .sq_pending      (sq_pending),
  .lookup_hit      (lookup_hit),
  .lookup_hold     (lookup_hold),
  .lookup_wait_idx (lookup_wait_idx)
);

// File: tb/alias_hold_predictor_bench.sv
module alias_hold_predictor_bench;
  localparam int ENTRIES  = 16;
  localparam int TAG_W    = 12;
  localparam int SQ_DEPTH = 16;
  localparam int IDX_W    = $clog2(SQ_DEPTH);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                clear_i = 1'b0;
  logic                train_valid = 1'b0;
  logic                train_ready;
  logic [TAG_W-1:0]    train_tag = '0;
  logic                lookup_valid = 1'b0;
  logic [TAG_W-1:0]    lookup_tag = '0;
  logic [IDX_W-1:0]    sq_head = '0;
  logic [IDX_W:0]      sq_older_cnt = '0;
  logic [SQ_DEPTH-1:0] sq_pending = '0;
  logic                lookup_hit;
  logic                lookup_hold;
  logic [IDX_W-1:0]    lookup_wait_idx;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alias_hold_predictor #(
    .ENTRIES (ENTRIES), .TAG_W (TAG_W), .SQ_DEPTH (SQ_DEPTH)
  ) u_alias_hold_predictor (
    .clk (clk), .rst_n (rst_n), .clear_i (clear_i),
    .train_valid (train_valid), .train_ready (train_ready), .train_tag (train_tag),
    .lookup_valid (lookup_valid), .lookup_tag (lookup_tag),
    .sq_head (sq_head), .sq_older_cnt (sq_older_cnt), .sq_pending (sq_pending),
    .lookup_hit (lookup_hit), .lookup_hold (lookup_hold),
    .lookup_wait_idx (lookup_wait_idx)
  );

  task automatic check(string req, string what, int actual, int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic train(logic [TAG_W-1:0] t);
    @(negedge clk);
    train_valid = 1'b1;
    train_tag   = t;
    @(negedge clk);
    train_valid = 1'b0;
  endtask

  // Combinational lookup probe, sampled mid-cycle.
  task automatic probe(logic [TAG_W-1:0] t, logic [IDX_W-1:0] hd,
                       logic [IDX_W:0] cnt, logic [SQ_DEPTH-1:0] pend);
    @(negedge clk);
    lookup_valid = 1'b1;
    lookup_tag   = t;
    sq_head      = hd;
    sq_older_cnt = cnt;
    sq_pending   = pend;
    #2;
  endtask

  task automatic expect_out(string req, int hit, int hold, int idx);
    check(req, "hit", int'(lookup_hit), hit);
    check(req, "hold", int'(lookup_hold), hold);
    check(req, "wait_idx", int'(lookup_wait_idx), idx);
  endtask

  task automatic t_reset_empty();
    probe(12'h123, 4'd0, 5'd16, 16'hFFFF);
    expect_out("R1", 0, 0, 0);
  endtask

  task automatic t_train_then_hit();
    train(12'h0A5);
    probe(12'h0A5, 4'd0, 5'd0, 16'h0000);
    expect_out("R2", 1, 0, 0);
    probe(12'h0A6, 4'd0, 5'd0, 16'h0000);
    expect_out("R2", 0, 0, 0);
  endtask

  task automatic t_dup_and_rr();
    // Table was cleared before: A=slot0, B=slot1, dup A skipped, 14 fill, D evicts A.
    train(12'h100);
    train(12'h200);
    train(12'h100);
    for (int i = 0; i < ENTRIES - 2; i++) train(12'h300 + TAG_W'(i));
    probe(12'h100, 4'd0, 5'd0, '0);
    expect_out("R4", 1, 0, 0);
    train(12'h7FF);
    probe(12'h100, 4'd0, 5'd0, '0);
    expect_out("R4", 0, 0, 0);
    probe(12'h200, 4'd0, 5'd0, '0);
    check("R3", "second tag kept after dup", int'(lookup_hit), 1);
    probe(12'h7FF, 4'd0, 5'd0, '0);
    check("R4", "newest tag present", int'(lookup_hit), 1);
  endtask

  task automatic t_miss_no_hold();
    probe(12'hBAD, 4'd0, 5'd16, 16'hFFFF);
    expect_out("R5", 0, 0, 0);
  endtask

  task automatic t_hold_oldest();
    train(12'h055);
    probe(12'h055, 4'd0, 5'd8, 16'b0000_0000_0100_1000);
    expect_out("R6", 1, 1, 3);
  endtask

  task automatic t_window_limits();
    probe(12'h055, 4'd0, 5'd3, 16'b0000_0000_0010_0000);
    expect_out("R7", 1, 0, 0);
    probe(12'h055, 4'd0, 5'd0, 16'hFFFF);
    expect_out("R7", 1, 0, 0);
  endtask

  task automatic t_wrap();
    probe(12'h055, 4'd12, 5'd8, 16'b0010_0000_0000_0010);
    expect_out("R8", 1, 1, 13);
    probe(12'h055, 4'd12, 5'd8, 16'b0000_0000_0001_0000);
    expect_out("R8", 1, 0, 0);
    probe(12'h055, 4'd5, 5'd16, 16'b0000_0000_0001_0000);
    expect_out("R8", 1, 1, 4);
  endtask

  task automatic t_hit_nothing_pending();
    probe(12'h055, 4'd2, 5'd10, 16'h0000);
    expect_out("R9", 1, 0, 0);
  endtask

  task automatic t_idle();
    probe(12'h055, 4'd0, 5'd8, 16'hFFFF);
    lookup_valid = 1'b0;
    #1;
    check("R11", "hit idle", int'(lookup_hit), 0);
    check("R11", "hold idle", int'(lookup_hold), 0);
  endtask

  task automatic t_clear();
    @(negedge clk);
    lookup_valid = 1'b0;
    clear_i      = 1'b1;
    train_valid  = 1'b1;
    train_tag    = 12'h0E0;
    #1;
    check("R12", "ready during clear", int'(train_ready), 0);
    @(negedge clk);
    clear_i     = 1'b0;
    train_valid = 1'b0;
    #1;
    check("R12", "ready after clear", int'(train_ready), 1);
    probe(12'h0E0, 4'd0, 5'd0, '0);
    check("R12", "tag offered in clear not kept", int'(lookup_hit), 0);
    probe(12'h055, 4'd0, 5'd0, '0);
    check("R10", "old tag gone", int'(lookup_hit), 0);
    probe(12'h0A5, 4'd0, 5'd0, '0);
    check("R10", "old tag gone", int'(lookup_hit), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_empty();
    t_train_then_hit();
    t_miss_no_hold();
    t_hold_oldest();
    t_window_limits();
    t_wrap();
    t_hit_nothing_pending();
    t_idle();
    t_clear();
    t_dup_and_rr();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule